// File: doc/BRIEF.md
# Prioritised External Interrupt Interface

This block sits between a set of peripheral request lines and a processor that has a single interrupt request input and answers a request with two acknowledge pulses. Each rising edge on a request line marks that line pending. The block keeps every pending line and picks the one with the best priority. When the processor is free to take it, the block raises an active-high, level-sensitive request. Line `k` carries type number `BASE_TYPE + k`, so line 0 has the lowest type number and the highest priority.

The first acknowledge pulse (active low) makes the block drop its request and freeze the chosen type number. The data bus stays undriven during that pulse. On the second pulse the block drives the frozen type number onto the 8-bit data output and records the line as in service. An in-service record is held per line, so service routines can nest. A new request is raised only when nothing is in service, or when the best pending line outranks the best in-service line. A single-cycle end-of-service pulse retires the best-priority in-service line and clears its pending bit.

Top module: `intr_prio_ctrl`

## Requirements
- R1: After reset, `intr_o` is 0, `data_oe_o` is 0 and `data_o` is 0. No line is pending and none is in service.
- R2: A 0-to-1 transition on `irq_i[k]` marks line k pending. If nothing is in service, `intr_o` rises within three clock cycles.
- R3: Once raised, `intr_o` stays at 1 while `inta_n_i` is high. It falls in the cycle after `inta_n_i` is first sampled low.
- R4: `data_oe_o` is 0 while `intr_o` is 1, during the first acknowledge pulse, and between the two pulses.
- R5: During the second acknowledge pulse, `data_oe_o` is 1 and `data_o` equals `BASE_TYPE` plus the lowest index among the lines that are pending and not in service. With the default `BASE_TYPE` of 32, line 0 gives 32 and line 7 gives 39.
- R6: The type number is frozen at the first acknowledge pulse. A better line that becomes pending between the two pulses does not change the number delivered.
- R7: While a line is in service, pending lines of equal or lower priority (index not less than the in-service index) do not raise `intr_o`.
- R8: A pending line with a lower index than every line in service raises `intr_o`, so that it nests over the current service.
- R9: An `eoi_i` pulse clears the lowest-index in-service line and its pending bit. A waiting line that is now allowed is then requested. `eoi_i` has no effect when nothing is in service.
- R10: A request line held at 1 creates only one pending event. It is not requested again after its service ends unless it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_IRQ | Peripheral request lines, edge-detected, synchronous to clk |
| inta_n_i | input | 1 | Acknowledge from the processor, active low, synchronous to clk |
| eoi_i | input | 1 | End-of-service pulse, one cycle wide |
| intr_o | output | 1 | Level-sensitive request to the processor |
| data_o | output | 8 | Type number, valid while data_oe_o is 1 |
| data_oe_o | output | 1 | Drive enable for the low data bus |

## Verification
The assertions assume the following about the inputs:
- The acknowledge pulses are synchronous and each is held low for at least two clock cycles.
- A pulse comes only after `intr_o` has been raised, and always in pairs.
- `eoi_i` is never asserted in the same cycle as a second acknowledge edge.

The bench meets these assumptions by driving everything from tasks on the falling clock edge. Each pulse is held low for two cycles with a two-cycle gap between the pulses. End-of-service is pulsed only while no acknowledge is in progress. The random phase draws request patterns and end-of-service commands and always completes an acknowledge pair before it applies the next stimulus.

// File: rtl/intr_pkg.sv
package intr_pkg;
    typedef enum logic [1:0] {
        ACK_IDLE   = 2'd0,
        ACK_REQ    = 2'd1,
        ACK_FIRST  = 2'd2,
        ACK_SECOND = 2'd3
    } ack_state_e;
endpackage

// File: rtl/intr_lowest_pick.sv
module intr_lowest_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]  mask_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = |mask_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/intr_ack_seq.sv
module intr_ack_seq
    import intr_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inta_n_i,
    input  logic          raise_i,
    input  logic [IW-1:0] best_idx_i,
    output logic          intr_o,
    output logic          drive_o,
    output logic [IW-1:0] vec_idx_o,
    output logic          commit_o
);
    typedef struct packed {
        ack_state_e    state;
        logic          inta_prev;
        logic [IW-1:0] vec;
    } seq_t;

    seq_t seq_d, seq_q;
    logic fall;

    always_comb begin
        seq_d           = seq_q;
        seq_d.inta_prev = inta_n_i;
        fall            = seq_q.inta_prev & ~inta_n_i;
        commit_o        = 1'b0;
        unique case (seq_q.state)
            ACK_IDLE:   if (raise_i) seq_d.state = ACK_REQ;
            ACK_REQ: begin
                if (fall) begin
                    seq_d.state = ACK_FIRST;
                    seq_d.vec   = best_idx_i;
                end
            end
            ACK_FIRST: begin
                if (fall) begin
                    seq_d.state = ACK_SECOND;
                    commit_o    = 1'b1;
                end
            end
            ACK_SECOND: if (inta_n_i) seq_d.state = ACK_IDLE;
            default:    seq_d.state = ACK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{state: ACK_IDLE, inta_prev: 1'b1, vec: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign intr_o    = (seq_q.state == ACK_REQ);
    assign drive_o   = (seq_q.state == ACK_SECOND);
    assign vec_idx_o = seq_q.vec;
endmodule

// File: rtl/intr_pend_track.sv
module intr_pend_track #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_i,
    input  logic          eoi_i,
    input  logic          eoi_vld_i,
    input  logic [IW-1:0] eoi_idx_i,
    input  logic          commit_i,
    input  logic [IW-1:0] commit_idx_i,
    output logic [N-1:0]  cand_o,
    output logic [N-1:0]  isr_o
);
    typedef struct packed {
        logic [N-1:0] irq_prev;
        logic [N-1:0] pend;
        logic [N-1:0] isr;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [N-1:0] retire;
    logic [N-1:0] enter;

    always_comb begin
        retire = '0;
        enter  = '0;
        if (eoi_i && eoi_vld_i) retire[eoi_idx_i]  = 1'b1;
        if (commit_i)           enter[commit_idx_i] = 1'b1;
        trk_d.irq_prev = irq_i;
        trk_d.pend     = (trk_q.pend & ~retire) | (irq_i & ~trk_q.irq_prev);
        trk_d.isr      = (trk_q.isr & ~retire) | enter;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign cand_o = trk_q.pend & ~trk_q.isr;
    assign isr_o  = trk_q.isr;
endmodule

// File: rtl/intr_prio_ctrl.sv
module intr_prio_ctrl #(
    parameter int NUM_IRQ   = 8,
    parameter int BASE_TYPE = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_i,
    input  logic               inta_n_i,
    input  logic               eoi_i,
    output logic               intr_o,
    output logic [7:0]         data_o,
    output logic               data_oe_o
);
    localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [NUM_IRQ-1:0] cand, isr;
    logic               best_vld, top_vld, raise, commit, drive;
    logic [IW-1:0]      best_idx, top_idx, vec_idx;

    intr_lowest_pick #(.N(NUM_IRQ), .IW(IW)) u_pick_cand (
        .mask_i(cand), .found_o(best_vld), .idx_o(best_idx)
    );

    intr_lowest_pick #(.N(NUM_IRQ), .IW(IW)) u_pick_isr (
        .mask_i(isr), .found_o(top_vld), .idx_o(top_idx)
    );

    assign raise = best_vld && (!top_vld || (best_idx < top_idx));

    intr_pend_track #(.N(NUM_IRQ), .IW(IW)) u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .irq_i        (irq_i),
        .eoi_i        (eoi_i),
        .eoi_vld_i    (top_vld),
        .eoi_idx_i    (top_idx),
        .commit_i     (commit),
        .commit_idx_i (vec_idx),
        .cand_o       (cand),
        .isr_o        (isr)
    );

    intr_ack_seq #(.IW(IW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .inta_n_i   (inta_n_i),
        .raise_i    (raise),
        .best_idx_i (best_idx),
        .intr_o     (intr_o),
        .drive_o    (drive),
        .vec_idx_o  (vec_idx),
        .commit_o   (commit)
    );

    assign data_oe_o = drive;
    assign data_o    = drive ? (8'(BASE_TYPE) + 8'(vec_idx)) : 8'h00;
endmodule

// File: rtl/intr_prio_ctrl_chk.sv
module intr_prio_ctrl_chk #(
    parameter int NUM_IRQ   = 8,
    parameter int BASE_TYPE = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       inta_n_i,
    input logic       intr_o,
    input logic [7:0] data_o,
    input logic       data_oe_o
);
    // R3: request is held while no acknowledge is seen
    a_r3_intr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_o && inta_n_i) |=> intr_o);

    // R3: request only drops after an acknowledge was sampled low
    a_r3_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_o) |-> !$past(inta_n_i));

    // R4: never drive the bus while still requesting
    a_r4_no_drive_req: assert property (@(posedge clk) disable iff (!rst_n)
        intr_o |-> !data_oe_o);

    // R4: driving starts only inside an acknowledge pulse
    a_r4_drive_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_oe_o) |-> !inta_n_i);

    // R5: delivered type lies in the configured window
    a_r5_type_range: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (int'(data_o) >= BASE_TYPE && int'(data_o) < BASE_TYPE + NUM_IRQ));

    // R6: delivered type stays steady while driven
    a_r6_type_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));
endmodule

bind intr_prio_ctrl intr_prio_ctrl_chk #(.NUM_IRQ(NUM_IRQ), .BASE_TYPE(BASE_TYPE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .inta_n_i  (inta_n_i),
    .intr_o    (intr_o),
    .data_o    (data_o),
    .data_oe_o (data_oe_o)
);

// File: tb/sim_intr_prio_ctrl.sv
module sim_intr_prio_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int BASE       = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq = '0;
    logic         inta_n = 1'b1;
    logic         eoi = 1'b0;
    logic         intr;
    logic [7:0]   data;
    logic         oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [N-1:0] m_pend = '0;
    logic [N-1:0] m_isr  = '0;

    intr_prio_ctrl #(.NUM_IRQ(N), .BASE_TYPE(BASE)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .inta_n_i(inta_n),
        .eoi_i(eoi), .intr_o(intr), .data_o(data), .data_oe_o(oe)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic int lowest(logic [N-1:0] m);
        for (int i = 0; i < N; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic bit exp_raise();
        int b = lowest(m_pend & ~m_isr);
        int t = lowest(m_isr);
        return (b >= 0) && (t < 0 || b < t);
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic set_lines(logic [N-1:0] v);
        @(negedge clk);
        m_pend = m_pend | (v & ~irq);
        irq = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic eoi_pulse();
        int t = lowest(m_isr);
        @(negedge clk) eoi = 1'b1;
        @(negedge clk) eoi = 1'b0;
        if (t >= 0) begin
            m_isr[t]  = 1'b0;
            m_pend[t] = 1'b0;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic first_pulse();
        @(negedge clk) inta_n = 1'b0;
        @(negedge clk);
        check(intr == 1'b0, "R3", int'(intr), 0);
        check(oe == 1'b0, "R4", int'(oe), 0);
        @(negedge clk) inta_n = 1'b1;
        @(negedge clk);
        check(oe == 1'b0, "R4", int'(oe), 0);
    endtask

    task automatic second_pulse(output int ty);
        @(negedge clk) inta_n = 1'b0;
        @(negedge clk);
        check(oe == 1'b1, "R5", int'(oe), 1);
        ty = int'(data);
        @(negedge clk) inta_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic full_ack(string req);
        int b = lowest(m_pend & ~m_isr);
        int ty;
        first_pulse();
        second_pulse(ty);
        check(ty == BASE + b, req, ty, BASE + b);
        if (b >= 0) m_isr[b] = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int ty;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(intr == 1'b0, "R1", int'(intr), 0);
        check(oe == 1'b0, "R1", int'(oe), 0);
        check(data == 8'h00, "R1", int'(data), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 single line raises request
        set_lines(8'b0000_1000);
        check(intr == 1'b1, "R2", int'(intr), 1);
        repeat (4) @(negedge clk);
        check(intr == 1'b1, "R3", int'(intr), 1);
        full_ack("R5");

        // R7 equal and lower priority do not raise
        set_lines(8'b0010_1000);
        check(intr == 1'b0, "R7", int'(intr), 0);

        // R8 higher priority nests
        set_lines(8'b0010_1010);
        check(intr == 1'b1, "R8", int'(intr), 1);
        full_ack("R8");

        // R9 retire nested, line 5 still blocked by line 3
        eoi_pulse();
        check(intr == 1'b0, "R9", int'(intr), 0);
        eoi_pulse();
        check(intr == 1'b1, "R9", int'(intr), 1);
        full_ack("R9");
        eoi_pulse();
        check(intr == 1'b0, "R9", int'(intr), 0);

        // R9 end-of-service with nothing in service has no effect
        eoi_pulse();
        check(intr == 1'b0, "R9", int'(intr), 0);

        // R6 frozen type number
        set_lines(8'b0100_0000);
        check(intr == 1'b1, "R6", int'(intr), 1);
        first_pulse();
        @(negedge clk);
        m_pend = m_pend | 8'b0000_0001;
        irq = 8'b0100_0001;
        @(negedge clk);
        second_pulse(ty);
        check(ty == BASE + 6, "R6", ty, BASE + 6);
        m_isr[6] = 1'b1;
        check(intr == 1'b1, "R8", int'(intr), 1);
        full_ack("R8");
        eoi_pulse();
        eoi_pulse();

        // R10 held lines do not re-request
        repeat (5) @(negedge clk);
        check(intr == 1'b0, "R10", int'(intr), 0);

        // R5 simultaneous requests pick lowest index
        set_lines(8'b0000_0000);
        set_lines(8'b0001_0100);
        check(intr == 1'b1, "R5", int'(intr), 1);
        full_ack("R5");
        eoi_pulse();
        full_ack("R5");
        eoi_pulse();

        // Random phase against the model
        for (int it = 0; it < 150; it++) begin
            if ($urandom % 4 == 0) eoi_pulse();
            else set_lines(N'($urandom & $urandom));
            check(intr == exp_raise(), "R7", int'(intr), int'(exp_raise()));
            if (exp_raise() && intr) full_ack("R5");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule